// File: doc/BRIEF.md
# Extension handle dispatch unit

This block sits between an instruction pipeline and a set of attached extension devices. Software first opens an interface by its 20-bit identifier. The block looks that identifier up among the interfaces loaded through its configuration port. It then allocates a slot in a handle table and records two things in that slot: the chosen interface and the address-space tag of the caller. The handle number is returned as the result.

Eight overloadable control opcodes then name a handle in the low bits of their first source operand. The block checks that the handle is live and owned by the calling address space. It checks that the interface implements the requested control slot. It then forwards the instruction's R-type bits to the device. A failed ownership check always produces the same exception, whether the handle is empty or belongs to someone else, so a process cannot probe for handles of other address spaces.

A close request validates the handle the same way. If the device supports shutdown, the block passes the shutdown to the device and frees the slot only when the device reports zero. Device traffic uses a valid/ready request with a separate response strobe. Only one request is in flight at a time.

Top module: `ext_dispatch`

## Requirements
- R1: After reset, `rsp_valid`, `dev_valid` and `busy` are low, `req_ready` is high, and every handle slot is empty.
- R2: An open (`req_kind`=1) whose `req_rs1[19:0]` matches an enabled interface responds with status 0 and data equal to the lowest-numbered free handle. The response appears in the cycle after the accepting edge.
- R3: An open whose identifier matches no enabled interface responds with status 1 and allocates nothing.
- R4: An open with every one of the `HANDLES` slots in use responds with status 2. A slot freed later is reused by the next open.
- R5: A control request (`req_kind`=0) or a close on a handle (`req_rs1[HW-1:0]`) that is empty, or whose recorded tag differs from `req_asid`, gives the same outcome in both cases. A control request responds with status 3; a close responds with status 0 and data 0xFFFFFFFF. No device request is made. Every response with nonzero status carries zero data.
- R6: A control request on an owned handle whose interface lacks slot `req_slot` responds with status 4. The reserved kind 3 also responds with status 4.
- R7: A valid control request raises `dev_valid` in the cycle after acceptance, with `dev_shut`=0, the interface index, `dev_slot`=`req_slot`, `dev_rbits`=`req_insn[31:7]` and `dev_arg`=`req_rs1[31:20]`. The response carries status 0 and `dev_result`, and appears in the cycle after `dev_resp_valid`.
- R8: A close on an owned handle (`req_kind`=2) whose interface has no shutdown support frees the slot at once and responds with status 0 and data 0.
- R9: A close on an owned handle whose interface supports shutdown sends a request with `dev_shut`=1. The device result is returned unchanged with status 0. The slot is freed only when that result is zero.
- R10: From acceptance until the response, `busy` is high and `req_ready` is low. `dev_valid` and its fields stay stable until `dev_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one interface configuration entry |
| cfg_idx | input | IF_W | Entry being written |
| cfg_en | input | 1 | Entry enabled |
| cfg_id | input | 20 | Interface identifier |
| cfg_slots | input | 8 | Mask of implemented control slots |
| cfg_shut | input | 1 | Interface supports shutdown |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | 0 control, 1 open, 2 close, 3 reserved |
| req_slot | input | 3 | Control slot 0..7 |
| req_insn | input | 32 | Instruction word |
| req_rs1 | input | 32 | Handle in low bits, or identifier for open; bits 31:20 extra argument |
| req_asid | input | ASID_W | Caller address-space tag |
| rsp_valid | output | 1 | Response strobe |
| rsp_status | output | 3 | 0 ok, 1 unknown interface, 2 table full, 3 no such interface, 4 no such instruction |
| rsp_data | output | 32 | Result |
| busy | output | 1 | Request in progress |
| dev_valid | output | 1 | Device request |
| dev_ready | input | 1 | Device takes request |
| dev_shut | output | 1 | Request is a shutdown |
| dev_if | output | IF_W | Target interface index |
| dev_slot | output | 3 | Control slot |
| dev_rbits | output | 25 | Instruction bits 31:7 |
| dev_arg | output | 12 | Operand bits 31:20 |
| dev_resp_valid | input | 1 | Device response strobe |
| dev_result | input | 32 | Device result |

## Verification
Requests that need no device (open, failed checks, closes without shutdown) respond in the cycle right after the accepting edge. The scoreboard records the acceptance cycle and requires a response latency of zero extra cycles for these. Device-bound requests respond one cycle after the stub's response strobe. For those the scoreboard checks content and order rather than a fixed latency, while the stub checks the forwarded fields and that `dev_valid` is held until it accepts. The bench also counts device requests, so any request made on a path that must not reach a device is caught.

// File: rtl/ext_pkg.sv
package ext_pkg;
  localparam int ID_W    = 20;
  localparam int SLOTS   = 8;
  localparam int RBITS_W = 25;
  localparam int ARG_W   = 12;

  typedef enum logic [1:0] {K_CTL = 2'd0, K_OPEN = 2'd1, K_CLOSE = 2'd2, K_RSVD = 2'd3} kind_e;
  typedef enum logic [2:0] {
    ST_OK = 3'd0, ST_OPEN_NOIF = 3'd1, ST_OPEN_FULL = 3'd2,
    ST_EXC_NOIF = 3'd3, ST_EXC_NOINSN = 3'd4
  } status_e;
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_SEND = 2'd1, S_WAIT = 2'd2} fsm_e;
endpackage

// File: rtl/ext_iface_cfg.sv
module ext_iface_cfg #(
  parameter int NUM_IF = 4,
  parameter int IF_W   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [IF_W-1:0] cfg_idx,
  input  logic            cfg_en,
  input  logic [19:0]     cfg_id,
  input  logic [7:0]      cfg_slots,
  input  logic            cfg_shut,
  input  logic [19:0]     look_id,
  output logic            look_hit,
  output logic [IF_W-1:0] look_idx,
  input  logic [IF_W-1:0] sel_idx,
  output logic [7:0]      sel_slots,
  output logic            sel_shut
);
  logic [NUM_IF-1:0] en_q;
  logic [19:0]       id_q    [NUM_IF];
  logic [7:0]        slots_q [NUM_IF];
  logic [NUM_IF-1:0] shut_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (cfg_we) en_q[cfg_idx] <= cfg_en;
  end

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      id_q[cfg_idx]    <= cfg_id;
      slots_q[cfg_idx] <= cfg_slots;
      shut_q[cfg_idx]  <= cfg_shut;
    end
  end

  // lowest-index enabled match wins
  always_comb begin
    look_hit = 1'b0;
    look_idx = '0;
    for (int i = NUM_IF - 1; i >= 0; i--) begin
      if (en_q[i] && id_q[i] == look_id) begin
        look_hit = 1'b1;
        look_idx = IF_W'(i);
      end
    end
  end

  assign sel_slots = slots_q[sel_idx];
  assign sel_shut  = shut_q[sel_idx];
endmodule

// File: rtl/ext_handle_tbl.sv
module ext_handle_tbl #(
  parameter int HANDLES = 16,
  parameter int HW      = 4,
  parameter int IF_W    = 2,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic [HW-1:0]     alloc_idx,
  input  logic [IF_W-1:0]   alloc_if,
  input  logic [ASID_W-1:0] alloc_asid,
  input  logic              clr,
  input  logic [HW-1:0]     clr_idx,
  input  logic [HW-1:0]     rd_idx,
  output logic              rd_vld,
  output logic [IF_W-1:0]   rd_if,
  output logic [ASID_W-1:0] rd_asid,
  output logic              free_ok,
  output logic [HW-1:0]     free_idx
);
  logic [HANDLES-1:0] vld_q;
  logic [IF_W-1:0]    if_mem   [HANDLES];
  logic [ASID_W-1:0]  asid_mem [HANDLES];

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else begin
      if (alloc) vld_q[alloc_idx] <= 1'b1;
      if (clr)   vld_q[clr_idx]   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      if_mem[alloc_idx]   <= alloc_if;
      asid_mem[alloc_idx] <= alloc_asid;
    end
  end

  assign rd_vld  = vld_q[rd_idx];
  assign rd_if   = if_mem[rd_idx];
  assign rd_asid = asid_mem[rd_idx];

  always_comb begin
    free_ok  = 1'b0;
    free_idx = '0;
    for (int i = HANDLES - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_ok  = 1'b1;
        free_idx = HW'(i);
      end
    end
  end
endmodule

// File: rtl/ext_dispatch.sv
module ext_dispatch #(
  parameter int NUM_IF  = 4,
  parameter int HANDLES = 16,
  parameter int ASID_W  = 8,
  localparam int IF_W   = (NUM_IF > 1) ? $clog2(NUM_IF) : 1,
  localparam int HW     = (HANDLES > 1) ? $clog2(HANDLES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IF_W-1:0]   cfg_idx,
  input  logic              cfg_en,
  input  logic [19:0]       cfg_id,
  input  logic [7:0]        cfg_slots,
  input  logic              cfg_shut,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [2:0]        req_slot,
  input  logic [31:0]       req_insn,
  input  logic [31:0]       req_rs1,
  input  logic [ASID_W-1:0] req_asid,
  output logic              rsp_valid,
  output logic [2:0]        rsp_status,
  output logic [31:0]       rsp_data,
  output logic              busy,
  output logic              dev_valid,
  input  logic              dev_ready,
  output logic              dev_shut,
  output logic [IF_W-1:0]   dev_if,
  output logic [2:0]        dev_slot,
  output logic [24:0]       dev_rbits,
  output logic [11:0]       dev_arg,
  input  logic              dev_resp_valid,
  input  logic [31:0]       dev_result
);
  import ext_pkg::*;

  fsm_e             state_q;
  logic             acc;
  logic [HW-1:0]    hsel;
  logic             look_hit;
  logic [IF_W-1:0]  look_idx;
  logic [7:0]       sel_slots;
  logic             sel_shut;
  logic             rd_vld, free_ok;
  logic [IF_W-1:0]  rd_if;
  logic [ASID_W-1:0] rd_asid;
  logic [HW-1:0]    free_idx;
  logic             owned;

  logic             go_dev, dec_shut, do_alloc, do_clr;
  status_e          loc_st;
  logic [31:0]      loc_dat;
  logic             shut_ok, clr_any;
  logic [HW-1:0]    clr_idx, pend_h_q;

  assign acc       = req_valid && (state_q == S_IDLE);
  assign req_ready = (state_q == S_IDLE);
  assign busy      = (state_q != S_IDLE);
  assign hsel      = req_rs1[HW-1:0];
  assign owned     = rd_vld && (rd_asid == req_asid);

  ext_iface_cfg #(.NUM_IF(NUM_IF), .IF_W(IF_W)) u_cfg (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_id(cfg_id),
    .cfg_slots(cfg_slots), .cfg_shut(cfg_shut),
    .look_id(req_rs1[19:0]), .look_hit(look_hit), .look_idx(look_idx),
    .sel_idx(rd_if), .sel_slots(sel_slots), .sel_shut(sel_shut)
  );

  ext_handle_tbl #(.HANDLES(HANDLES), .HW(HW), .IF_W(IF_W), .ASID_W(ASID_W)) u_tbl (
    .clk(clk), .rst(rst),
    .alloc(acc && do_alloc), .alloc_idx(free_idx), .alloc_if(look_idx), .alloc_asid(req_asid),
    .clr(clr_any), .clr_idx(clr_idx),
    .rd_idx(hsel), .rd_vld(rd_vld), .rd_if(rd_if), .rd_asid(rd_asid),
    .free_ok(free_ok), .free_idx(free_idx)
  );

  // request decision
  always_comb begin
    go_dev   = 1'b0;
    dec_shut = 1'b0;
    do_alloc = 1'b0;
    do_clr   = 1'b0;
    loc_st   = ST_OK;
    loc_dat  = '0;
    case (kind_e'(req_kind))
      K_OPEN: begin
        if (!look_hit)     loc_st = ST_OPEN_NOIF;
        else if (!free_ok) loc_st = ST_OPEN_FULL;
        else begin
          do_alloc = 1'b1;
          loc_dat  = 32'(free_idx);
        end
      end
      K_CLOSE: begin
        if (!owned) loc_dat = '1;
        else if (!sel_shut) do_clr = 1'b1;
        else begin
          go_dev   = 1'b1;
          dec_shut = 1'b1;
        end
      end
      K_CTL: begin
        if (!owned) loc_st = ST_EXC_NOIF;
        else if (!sel_slots[req_slot]) loc_st = ST_EXC_NOINSN;
        else go_dev = 1'b1;
      end
      default: loc_st = ST_EXC_NOINSN;
    endcase
  end

  assign shut_ok = (state_q == S_WAIT) && dev_resp_valid && dev_shut && (dev_result == '0);
  assign clr_any = shut_ok || (acc && do_clr);
  assign clr_idx = shut_ok ? pend_h_q : hsel;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      rsp_valid  <= 1'b0;
      rsp_status <= '0;
      rsp_data   <= '0;
      dev_valid  <= 1'b0;
      dev_shut   <= 1'b0;
      dev_if     <= '0;
      dev_slot   <= '0;
      dev_rbits  <= '0;
      dev_arg    <= '0;
      pend_h_q   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        S_IDLE: if (acc) begin
          if (go_dev) begin
            dev_valid <= 1'b1;
            dev_shut  <= dec_shut;
            dev_if    <= rd_if;
            dev_slot  <= req_slot;
            dev_rbits <= req_insn[31:7];
            dev_arg   <= req_rs1[31:20];
            pend_h_q  <= hsel;
            state_q   <= S_SEND;
          end else begin
            rsp_valid  <= 1'b1;
            rsp_status <= loc_st;
            rsp_data   <= loc_dat;
          end
        end
        S_SEND: if (dev_ready) begin
          dev_valid <= 1'b0;
          state_q   <= S_WAIT;
        end
        S_WAIT: if (dev_resp_valid) begin
          rsp_valid  <= 1'b1;
          rsp_status <= ST_OK;
          rsp_data   <= dev_result;
          state_q    <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ext_dispatch_chk.sv
module ext_dispatch_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        busy,
  input logic        rsp_valid,
  input logic [2:0]  rsp_status,
  input logic [31:0] rsp_data,
  input logic        dev_valid,
  input logic        dev_ready,
  input logic        dev_shut,
  input logic [2:0]  dev_slot,
  input logic [24:0] dev_rbits,
  input logic        dev_resp_valid
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) rst |=> (!rsp_valid && !dev_valid && !busy));

  // R10
  dev_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dev_valid && !dev_ready |=> dev_valid && $stable(dev_rbits) && $stable(dev_slot) && $stable(dev_shut));

  // R10
  idle_nodev_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !dev_valid);

  // R7
  launch_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_valid) |-> $past(req_valid && req_ready));

  // R7
  rsp_after_dev_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !dev_valid && dev_resp_valid |=> rsp_valid && !busy && rsp_status == 3'd0);

  // R5
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_status != 3'd0 |-> rsp_data == 32'd0);
endmodule

bind ext_dispatch ext_dispatch_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data),
  .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_shut(dev_shut), .dev_slot(dev_slot),
  .dev_rbits(dev_rbits), .dev_resp_valid(dev_resp_valid)
);

// File: tb/sim_ext_dispatch.sv
module sim_ext_dispatch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_en = 1'b0, cfg_shut = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [19:0] cfg_id = '0;
  logic [7:0]  cfg_slots = '0;
  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_kind = '0;
  logic [2:0]  req_slot = '0;
  logic [31:0] req_insn = '0, req_rs1 = '0;
  logic [7:0]  req_asid = '0;
  logic        rsp_valid, busy, dev_valid, dev_shut;
  logic [2:0]  rsp_status, dev_slot;
  logic [31:0] rsp_data;
  logic [1:0]  dev_if;
  logic [24:0] dev_rbits;
  logic [11:0] dev_arg;
  logic        dev_ready, dev_resp_valid;
  logic [31:0] dev_result;

  always #2 clk = ~clk;

  ext_dispatch u0 (.*);

  typedef struct {
    logic [2:0]  st;
    logic [31:0] dat;
    bit          local_op;
    int          acc_cyc;
    string       req;
  } item_t;

  item_t sb[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  int dev_count = 0, dev_exp = 0;
  logic [1:0]  e_if;
  logic [2:0]  e_slot;
  logic        e_shut;
  logic [24:0] e_rbits;
  logic [11:0] e_arg;
  logic [31:0] shut_res = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] stub_fn(input logic [1:0] fi, input logic [2:0] sl,
                                          input logic [24:0] rb, input logic [11:0] ar);
    return {2'b00, fi, sl, rb} ^ {ar, 20'h0};
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) check(1'b0, "R10", "unexpected response", 64'(rsp_data), 0);
      else begin
        item_t it;
        it = sb.pop_front();
        check(rsp_status == it.st, it.req, "status", 64'(rsp_status), 64'(it.st));
        check(rsp_data == it.dat, it.req, "data", 64'(rsp_data), 64'(it.dat));
        if (it.local_op) check(cyc == it.acc_cyc, it.req, "latency", 64'(cyc - it.acc_cyc), 0);
      end
    end
  end

  // device stub responder
  initial begin
    dev_ready = 1'b0; dev_resp_valid = 1'b0; dev_result = '0;
    forever begin
      @(negedge clk);
      if (dev_valid) begin
        logic [31:0] r;
        dev_count++;
        check(dev_shut == e_shut, "R9", "dev_shut", 64'(dev_shut), 64'(e_shut));
        check(dev_if == e_if, "R7", "dev_if", 64'(dev_if), 64'(e_if));
        check(dev_rbits == e_rbits, "R7", "dev_rbits", 64'(dev_rbits), 64'(e_rbits));
        if (!e_shut) begin
          check(dev_slot == e_slot, "R7", "dev_slot", 64'(dev_slot), 64'(e_slot));
          check(dev_arg == e_arg, "R7", "dev_arg", 64'(dev_arg), 64'(e_arg));
        end
        r = dev_shut ? shut_res : stub_fn(dev_if, dev_slot, dev_rbits, dev_arg);
        repeat (2) @(negedge clk);
        check(dev_valid == 1'b1, "R10", "dev_valid held", 64'(dev_valid), 1);
        dev_ready = 1'b1;
        @(negedge clk);
        dev_ready = 1'b0;
        dev_resp_valid = 1'b1;
        dev_result = r;
        @(negedge clk);
        dev_resp_valid = 1'b0;
      end
    end
  end

  task automatic cfg(input logic [1:0] i, input logic en, input logic [19:0] id,
                     input logic [7:0] sl, input logic sh);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = i; cfg_en = en; cfg_id = id; cfg_slots = sl; cfg_shut = sh;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input logic [1:0] k, input logic [2:0] sl, input logic [31:0] rs1,
                       input logic [31:0] insn, input logic [7:0] asid,
                       input logic [2:0] est, input logic [31:0] edat,
                       input bit local_op, input string req);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    it.st = est; it.dat = edat; it.local_op = local_op; it.acc_cyc = cyc + 1; it.req = req;
    sb.push_back(it);
    req_kind = k; req_slot = sl; req_rs1 = rs1; req_insn = insn; req_asid = asid;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!local_op) begin
      // R10: busy through the device exchange
      check(busy == 1'b1 && req_ready == 1'b0, "R10", "busy/ready", {busy, req_ready}, 2'b10);
    end
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic dev_op(input logic [1:0] k, input logic [2:0] sl, input logic [31:0] rs1,
                        input logic [31:0] insn, input logic [7:0] asid,
                        input logic [1:0] fi, input string req);
    logic [31:0] ed;
    e_if = fi; e_slot = sl; e_shut = (k == 2'd2); e_rbits = insn[31:7]; e_arg = rs1[31:20];
    ed = e_shut ? shut_res : stub_fn(fi, sl, insn[31:7], rs1[31:20]);
    dev_exp++;
    issue(k, sl, rs1, insn, asid, 3'd0, ed, 1'b0, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!rsp_valid && !dev_valid && !busy && req_ready, "R1", "reset outputs",
          {rsp_valid, dev_valid, busy, req_ready}, 4'b0001);

    cfg(2'd0, 1'b1, 20'h12345, 8'h0F, 1'b1);
    cfg(2'd1, 1'b1, 20'hABCDE, 8'h81, 1'b0);
    cfg(2'd2, 1'b0, 20'h55555, 8'hFF, 1'b1);

    issue(2'd0, 3'd0, 32'h0, 32'h0, 8'd1, 3'd3, 0, 1'b1, "R1");          // empty after reset
    issue(2'd1, 3'd0, 32'h55555, 32'h0, 8'd1, 3'd1, 0, 1'b1, "R3");      // disabled id
    issue(2'd1, 3'd0, 32'h12345, 32'h0, 8'd1, 3'd0, 0, 1'b1, "R2");
    issue(2'd1, 3'd0, 32'hABCDE, 32'h0, 8'd1, 3'd0, 1, 1'b1, "R2");
    issue(2'd1, 3'd0, 32'hABCDE, 32'h0, 8'd2, 3'd0, 2, 1'b1, "R2");

    dev_op(2'd0, 3'd2, 32'hABC0_0000, 32'h1234_5678, 8'd1, 2'd0, "R7");
    issue(2'd0, 3'd5, 32'h0, 32'h0, 8'd1, 3'd4, 0, 1'b1, "R6");
    issue(2'd3, 3'd0, 32'h0, 32'h0, 8'd1, 3'd4, 0, 1'b1, "R6");
    dev_op(2'd0, 3'd7, 32'h0003_0001, 32'hFEDC_BA98, 8'd1, 2'd1, "R7");
    issue(2'd0, 3'd0, 32'h2, 32'h0, 8'd1, 3'd3, 0, 1'b1, "R5");          // tag mismatch

    issue(2'd2, 3'd0, 32'h2, 32'h0, 8'd1, 3'd0, 32'hFFFF_FFFF, 1'b1, "R5");
    issue(2'd2, 3'd0, 32'h7, 32'h0, 8'd1, 3'd0, 32'hFFFF_FFFF, 1'b1, "R5");
    issue(2'd2, 3'd0, 32'h1, 32'h0, 8'd1, 3'd0, 0, 1'b1, "R8");
    issue(2'd0, 3'd0, 32'h1, 32'h0, 8'd1, 3'd3, 0, 1'b1, "R8");          // freed
    issue(2'd1, 3'd0, 32'hABCDE, 32'h0, 8'd3, 3'd0, 1, 1'b1, "R2");      // lowest free reused

    shut_res = 32'd5;
    dev_op(2'd2, 3'd0, 32'h0, 32'h0BAD_0F00, 8'd1, 2'd0, "R9");
    dev_op(2'd0, 3'd1, 32'h0, 32'h0000_1080, 8'd1, 2'd0, "R9");          // entry kept
    shut_res = 32'd0;
    dev_op(2'd2, 3'd0, 32'h0, 32'h0000_0F00, 8'd1, 2'd0, "R9");
    issue(2'd0, 3'd1, 32'h0, 32'h0, 8'd1, 3'd3, 0, 1'b1, "R9");          // freed

    issue(2'd1, 3'd0, 32'h12345, 32'h0, 8'd4, 3'd0, 0, 1'b1, "R4");
    for (int h = 3; h < 16; h++)
      issue(2'd1, 3'd0, 32'h12345, 32'h0, 8'd4, 3'd0, 32'(h), 1'b1, "R4");
    issue(2'd1, 3'd0, 32'h12345, 32'h0, 8'd4, 3'd2, 0, 1'b1, "R4");
    dev_op(2'd2, 3'd0, 32'h9, 32'h0, 8'd4, 2'd0, "R4");
    issue(2'd1, 3'd0, 32'hABCDE, 32'h0, 8'd4, 3'd0, 9, 1'b1, "R4");

    repeat (4) @(negedge clk);
    check(dev_count == dev_exp, "R5", "device request count", 64'(dev_count), 64'(dev_exp));
    finish_run();
  end
endmodule